// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the type-1 header fields that belong only to a PCI-to-PCI bridge. These fields are the three bus numbers, the secondary latency timer, the I/O, memory and prefetchable window base/limit words with their upper extensions, bridge control, secondary status, class code and header type. Configuration writes arrive as a dword index with four byte enables. Reads are combinational on the dword index, so a read has no wait states. Generic type-0 registers and the address decode that uses the windows live elsewhere.

Two outputs let neighbouring logic react to writes. The first is a one-cycle remap strobe. It tells the window decoder that the command register, a window register or bridge control may have changed. The second is a one-cycle secondary bus reset pulse, raised when software sets the bus-reset control bit. A separate one-cycle request loads a preset that closes every forwarding window.

Top module: `bridge_cfg_regs`

## Requirements
- R1: While rst_n is low, the following read as zero: the bus-number dword (index 6), the window address bits, the prefetchable upper dwords (10, 11), the I/O upper dword (12) and bridge control (index 15, bits 31:16). The window type nibbles keep their configured values, so index 7 reads 0x00A00101 and index 9 reads 0x00010001 when IO_32B and PREF_64B are set. remap_stb and sec_rst_pulse are low.
- R2: Index 2 reads 0x06040000 (bridge class, revision 0). Index 3 reads header type 0x01 in bits 22:16, with bit 23 equal to mf_strap. All other bits of index 3 are zero.
- R3: Bits 31:16 of index 7 (secondary status) read 0x00A0, meaning 66 MHz capable and fast back-to-back capable.
- R4: Bits 3:0 of each window base and each window limit are read-only type bits. They read 1 for I/O when IO_32B is set, 1 for prefetchable when PREF_64B is set, and 0 for memory. Only the address bits above them take written data.
- R5: Each byte enable in cfg_be acts on its own byte lane. A write changes only the enabled bytes of the addressed dword, and the new value is visible from the cycle after the write edge.
- R6: A one-cycle fwd_off_req sets every address bit of the I/O, memory and prefetchable bases to one. It clears those of the three limits and zeroes indices 10 and 11. Bus numbers, the I/O upper dword and bridge control are not changed. The preset wins over a write in the same cycle.
- R7: remap_stb is high for the cycle after a write edge when an enabled byte falls in one of these byte offsets: 0x04-0x05, 0x1C-0x1D, 0x20-0x33 or 0x3E-0x3F. It is low after any other cycle.
- R8: sec_rst_pulse is high for one cycle after a write edge that changes bit 22 of index 15 (bridge-control bus reset) from 0 to 1. Writing it while it is already 1, or clearing it, gives no pulse.
- R9: Indices outside {2, 3, 6, 7, 8, 9, 10, 11, 12, 15} read zero, as do bits 15:0 of index 15.
- R10: Writes to read-only words (class code, header type, secondary status, unimplemented indices) leave their read values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Dword index into the 256-byte header space |
| cfg_be | input | 4 | Byte enables, bit i for bits 8i+7:8i |
| cfg_wdata | input | 32 | Write data |
| fwd_off_req | input | 1 | Load the preset that closes all windows |
| mf_strap | input | 1 | Multi-function bit reported in header type |
| cfg_rdata | output | 32 | Combinational read data for cfg_dw_addr |
| remap_stb | output | 1 | One-cycle window-remap strobe |
| sec_rst_pulse | output | 1 | One-cycle secondary bus reset pulse |

## Verification
Some properties are checked on every cycle:
- the constant identity and status words;
- the type nibbles of the memory window;
- zero reads from unused indices;
- the remap strobe, against a byte-range model of the trigger offsets;
- the bus-reset pulse, matched to a rising control bit in both directions;
- the preset's result whenever the memory window is read right after it.

Other behaviours depend on history and can only be shown by the bench's scenarios. These are the masking of byte lanes over partial writes, the absence of a pulse on repeated or masked-off writes, a preset colliding with a write, and values held through a preset and through a later reset.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int ADDR_W   = 6;
    localparam int NSLOT    = 8;
    localparam int RST_BIT  = 22;

    localparam logic [ADDR_W-1:0] IX_CMD   = 6'd1;
    localparam logic [ADDR_W-1:0] IX_CLASS = 6'd2;
    localparam logic [ADDR_W-1:0] IX_HDR   = 6'd3;
    localparam logic [ADDR_W-1:0] IX_BUS   = 6'd6;
    localparam logic [ADDR_W-1:0] IX_IO    = 6'd7;
    localparam logic [ADDR_W-1:0] IX_MEM   = 6'd8;
    localparam logic [ADDR_W-1:0] IX_PREF  = 6'd9;
    localparam logic [ADDR_W-1:0] IX_PBU   = 6'd10;
    localparam logic [ADDR_W-1:0] IX_PLU   = 6'd11;
    localparam logic [ADDR_W-1:0] IX_IOU   = 6'd12;
    localparam logic [ADDR_W-1:0] IX_BCTL  = 6'd15;

    localparam logic [31:0] CLASS_WORD = 32'h0604_0000;
    localparam logic [15:0] SEC_STAT   = 16'h00A0;
    localparam logic [6:0]  HDR_KIND   = 7'h01;

    // storage slot order
    typedef enum int {
        SL_BUS = 0, SL_IO = 1, SL_MEM = 2, SL_PREF = 3,
        SL_PBU = 4, SL_PLU = 5, SL_IOU = 6, SL_BCTL = 7
    } slot_e;

    function automatic logic [ADDR_W-1:0] slot_index(int s);
        case (s)
            SL_BUS:  return IX_BUS;
            SL_IO:   return IX_IO;
            SL_MEM:  return IX_MEM;
            SL_PREF: return IX_PREF;
            SL_PBU:  return IX_PBU;
            SL_PLU:  return IX_PLU;
            SL_IOU:  return IX_IOU;
            default: return IX_BCTL;
        endcase
    endfunction

    function automatic logic [31:0] slot_rst(int s, bit io32, bit p64);
        logic [3:0] iot;
        logic [3:0] pt;
        iot = io32 ? 4'h1 : 4'h0;
        pt  = p64  ? 4'h1 : 4'h0;
        case (s)
            SL_IO:   return {SEC_STAT, 4'h0, iot, 4'h0, iot};
            SL_PREF: return {12'h000, pt, 12'h000, pt};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] slot_wmask(int s);
        case (s)
            SL_IO:            return 32'h0000_F0F0;
            SL_MEM, SL_PREF:  return 32'hFFF0_FFF0;
            SL_BCTL:          return 32'hFFFF_0000;
            default:          return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] slot_pmask(int s);
        case (s)
            SL_IO:            return 32'h0000_F0F0;
            SL_MEM, SL_PREF:  return 32'hFFF0_FFF0;
            SL_PBU, SL_PLU:   return 32'hFFFF_FFFF;
            default:          return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] slot_pval(int s);
        case (s)
            SL_IO:            return 32'h0000_00F0;
            SL_MEM, SL_PREF:  return 32'h0000_FFF0;
            default:          return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/bcfg_field_reg.sv
module bcfg_field_reg #(
    parameter logic [31:0] RST_V = 32'h0,
    parameter logic [31:0] WMASK = 32'hFFFF_FFFF,
    parameter logic [31:0] PMASK = 32'h0,
    parameter logic [31:0] PVAL  = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        preset,
    output logic [31:0] q
);

    logic [31:0] nxt;

    always_comb begin
        nxt = q;
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) begin
                    nxt[8*b +: 8] = (q[8*b +: 8] & ~WMASK[8*b +: 8]) |
                                    (wdata[8*b +: 8] & WMASK[8*b +: 8]);
                end
            end
        end
        if (preset) begin
            nxt = (nxt & ~PMASK) | (PVAL & PMASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_V;
        else        q <= nxt;
    end

endmodule

// File: rtl/bcfg_event_gen.sv
module bcfg_event_gen
    import bcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic              new_rst_bit,
    input  logic              cur_rst_bit,
    output logic              remap_stb,
    output logic              sec_rst_pulse
);

    logic win_touch;
    logic rst_rise;

    always_comb begin
        unique case (addr)
            IX_CMD, IX_IO:                          win_touch = |be[1:0];
            IX_MEM, IX_PREF, IX_PBU, IX_PLU, IX_IOU: win_touch = |be;
            IX_BCTL:                                win_touch = |be[3:2];
            default:                                win_touch = 1'b0;
        endcase
    end

    assign rst_rise = wr && (addr == IX_BCTL) && be[RST_BIT/8] &&
                      new_rst_bit && !cur_rst_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remap_stb     <= 1'b0;
            sec_rst_pulse <= 1'b0;
        end else begin
            remap_stb     <= wr && win_touch;
            sec_rst_pulse <= rst_rise;
        end
    end

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bcfg_pkg::*;
#(
    parameter bit IO_32B   = 1'b1,
    parameter bit PREF_64B = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_dw_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              fwd_off_req,
    input  logic              mf_strap,
    output logic [31:0]       cfg_rdata,
    output logic              remap_stb,
    output logic              sec_rst_pulse
);

    logic [31:0] slot_q [NSLOT];
    logic        bus_rst_bit;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [31:0] RV = slot_rst(g, IO_32B, PREF_64B);
        localparam logic [31:0] WM = slot_wmask(g);
        localparam logic [31:0] PM = slot_pmask(g);
        localparam logic [31:0] PV = slot_pval(g);
        logic sel;
        assign sel = cfg_wr && (cfg_dw_addr == slot_index(g));
        bcfg_field_reg #(.RST_V(RV), .WMASK(WM), .PMASK(PM), .PVAL(PV)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (sel),
            .be     (cfg_be),
            .wdata  (cfg_wdata),
            .preset (fwd_off_req),
            .q      (slot_q[g])
        );
    end

    assign bus_rst_bit = slot_q[SL_BCTL][RST_BIT];

    bcfg_event_gen u_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (cfg_wr),
        .addr          (cfg_dw_addr),
        .be            (cfg_be),
        .new_rst_bit   (cfg_wdata[RST_BIT]),
        .cur_rst_bit   (bus_rst_bit),
        .remap_stb     (remap_stb),
        .sec_rst_pulse (sec_rst_pulse)
    );

    always_comb begin
        cfg_rdata = 32'h0;
        if (cfg_dw_addr == IX_CLASS) cfg_rdata = CLASS_WORD;
        if (cfg_dw_addr == IX_HDR)   cfg_rdata = {8'h00, mf_strap, HDR_KIND, 16'h0000};
        for (int s = 0; s < NSLOT; s++) begin
            if (cfg_dw_addr == slot_index(s)) cfg_rdata = slot_q[s];
        end
    end

endmodule

// File: rtl/bcfg_chk.sv
module bcfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [5:0]  cfg_dw_addr,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_rdata,
    input logic        fwd_off_req,
    input logic        remap_stb,
    input logic        sec_rst_pulse,
    input logic        bus_rst_bit
);

    function automatic logic in_window(logic [7:0] b);
        return (b >= 8'h04 && b <= 8'h05) || (b >= 8'h1C && b <= 8'h1D) ||
               (b >= 8'h20 && b <= 8'h33) || (b >= 8'h3E && b <= 8'h3F);
    endfunction

    logic win_hit;
    always_comb begin
        win_hit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (cfg_be[i] && in_window({cfg_dw_addr, i[1:0]})) win_hit = 1'b1;
        end
    end

    logic implemented;
    assign implemented = cfg_dw_addr inside {6'd2, 6'd3, 6'd6, 6'd7, 6'd8,
                                             6'd9, 6'd10, 6'd11, 6'd12, 6'd15};

    assert_remap_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && win_hit) |=> remap_stb);

    assert_remap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && win_hit) |=> !remap_stb);

    assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rst_pulse |-> (bus_rst_bit && !$past(bus_rst_bit)));

    assert_rise_gives_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_bit) |-> sec_rst_pulse);

    assert_class_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_addr == 6'd2) |-> (cfg_rdata == 32'h0604_0000));

    assert_sec_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_addr == 6'd7) |-> (cfg_rdata[31:16] == 16'h00A0));

    assert_mem_type_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_addr == 6'd8) |-> (cfg_rdata[3:0] == 4'h0 && cfg_rdata[19:16] == 4'h0));

    assert_fwd_off_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_off_req && cfg_dw_addr == 6'd8) ##1 (cfg_dw_addr == 6'd8)
        |-> (cfg_rdata == 32'h0000_FFF0));

    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !implemented |-> (cfg_rdata == 32'h0));

endmodule

bind bridge_cfg_regs bcfg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_dw_addr   (cfg_dw_addr),
    .cfg_be        (cfg_be),
    .cfg_rdata     (cfg_rdata),
    .fwd_off_req   (fwd_off_req),
    .remap_stb     (remap_stb),
    .sec_rst_pulse (sec_rst_pulse),
    .bus_rst_bit   (bus_rst_bit)
);

// File: tb/sim_bridge_cfg_regs.sv
module sim_bridge_cfg_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    // {addr[6], be[4], wdata[32], expected read[32], expected remap[1]}
    localparam logic [74:0] VEC [NVEC] = '{
        {6'd6,  4'hF, 32'h4005_0301, 32'h4005_0301, 1'b0},  // R5 bus numbers
        {6'd7,  4'h1, 32'hFFFF_FFFF, 32'h00A0_01F1, 1'b1},  // R4 R7 io base
        {6'd7,  4'h2, 32'h0000_2300, 32'h00A0_21F1, 1'b1},  // R5 io limit
        {6'd8,  4'hF, 32'h1234_5678, 32'h1230_5670, 1'b1},  // R4 mem
        {6'd9,  4'h3, 32'hFFFF_FFFF, 32'h0001_FFF1, 1'b1},  // R4 R5 pref
        {6'd10, 4'h4, 32'h00AB_0000, 32'h00AB_0000, 1'b1},  // R5 upper
        {6'd12, 4'hF, 32'hBEEF_CAFE, 32'hBEEF_CAFE, 1'b1},  // R7 io upper
        {6'd15, 4'h3, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},  // R7 R9 low half
        {6'd15, 4'h8, 32'h0800_0000, 32'h0800_0000, 1'b1},  // R7 bctl
        {6'd2,  4'hF, 32'hFFFF_FFFF, 32'h0604_0000, 1'b0},  // R10 class
        {6'd1,  4'h1, 32'h0000_0007, 32'h0000_0000, 1'b1},  // R7 command
        {6'd1,  4'hC, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},  // R7 status half
        {6'd20, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},  // R9 R10 unused
        {6'd11, 4'hF, 32'h1122_3344, 32'h1122_3344, 1'b1},  // R7 upper limit
        {6'd6,  4'h2, 32'h0000_AA00, 32'h4005_AA01, 1'b0}   // R5 one lane
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fwd_off_req = 1'b0;
    logic        mf_strap = 1'b0;
    logic [31:0] cfg_rdata;
    logic        remap_stb;
    logic        sec_rst_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_cfg_regs u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_dw_addr   (cfg_dw_addr),
        .cfg_be        (cfg_be),
        .cfg_wdata     (cfg_wdata),
        .fwd_off_req   (fwd_off_req),
        .mf_strap      (mf_strap),
        .cfg_rdata     (cfg_rdata),
        .remap_stb     (remap_stb),
        .sec_rst_pulse (sec_rst_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        cfg_dw_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d,
                      input logic fwd);
        cfg_dw_addr = a;
        cfg_be      = b;
        cfg_wdata   = d;
        cfg_wr      = 1'b1;
        fwd_off_req = fwd;
        @(posedge clk);
        @(negedge clk);
        cfg_wr      = 1'b0;
        fwd_off_req = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state (rst_n still low)
        rd_chk("R1 bus", 6'd6, 32'h0);
        rd_chk("R1 io", 6'd7, 32'h00A0_0101);
        rd_chk("R1 mem", 6'd8, 32'h0);
        rd_chk("R1 pref", 6'd9, 32'h0001_0001);
        rd_chk("R1 pbu", 6'd10, 32'h0);
        rd_chk("R1 plu", 6'd11, 32'h0);
        rd_chk("R1 iou", 6'd12, 32'h0);
        rd_chk("R1 bctl", 6'd15, 32'h0);
        chk("R1 remap", {31'h0, remap_stb}, 32'h0);
        chk("R1 secrst", {31'h0, sec_rst_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 header identity
        rd_chk("R2 class", 6'd2, 32'h0604_0000);
        rd_chk("R2 hdr mf0", 6'd3, 32'h0001_0000);
        mf_strap = 1'b1;
        rd_chk("R2 hdr mf1", 6'd3, 32'h0081_0000);
        rd_chk("R3 secstat", 6'd7, 32'h00A0_0101);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][74:69], VEC[i][68:65], VEC[i][64:33], 1'b0);
            chk($sformatf("R5/R7 vec%0d remap", i), {31'h0, remap_stb}, {31'h0, VEC[i][0]});
            chk($sformatf("R4/R5/R9/R10 vec%0d read", i), cfg_rdata, VEC[i][32:1]);
        end

        // R8 secondary bus reset edge
        wr(6'd15, 4'h4, 32'h0040_0000, 1'b0);
        chk("R8 pulse on rise", {31'h0, sec_rst_pulse}, 32'h1);
        rd_chk("R8 bctl", 6'd15, 32'h0840_0000);
        @(negedge clk); #1;
        chk("R8 pulse one cycle", {31'h0, sec_rst_pulse}, 32'h0);
        wr(6'd15, 4'h4, 32'h0040_0000, 1'b0);
        chk("R8 no pulse when set", {31'h0, sec_rst_pulse}, 32'h0);
        wr(6'd15, 4'h4, 32'h0000_0000, 1'b0);
        chk("R8 no pulse on clear", {31'h0, sec_rst_pulse}, 32'h0);
        wr(6'd15, 4'h3, 32'h0040_0000, 1'b0);
        chk("R8 masked lane", {31'h0, sec_rst_pulse}, 32'h0);
        wr(6'd15, 4'h4, 32'h0040_0000, 1'b0);
        chk("R8 pulse again", {31'h0, sec_rst_pulse}, 32'h1);

        // R6 disable forwarding
        wr(6'd0, 4'h0, 32'h0, 1'b1);
        rd_chk("R6 io", 6'd7, 32'h00A0_01F1);
        rd_chk("R6 mem", 6'd8, 32'h0000_FFF0);
        rd_chk("R6 pref", 6'd9, 32'h0001_FFF1);
        rd_chk("R6 pbu", 6'd10, 32'h0);
        rd_chk("R6 plu", 6'd11, 32'h0);
        rd_chk("R6 iou kept", 6'd12, 32'hBEEF_CAFE);
        rd_chk("R6 bus kept", 6'd6, 32'h4005_AA01);
        rd_chk("R6 bctl kept", 6'd15, 32'h0840_0000);
        wr(6'd8, 4'hF, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R5 mem open", 6'd8, 32'hFFF0_FFF0);
        wr(6'd8, 4'hF, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R6 preset wins", 6'd8, 32'h0000_FFF0);

        // R1 reset mid-run
        rst_n = 1'b0;
        #1;
        rd_chk("R1 mem again", 6'd8, 32'h0);
        rd_chk("R1 bctl again", 6'd15, 32'h0);
        rd_chk("R1 plu again", 6'd11, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

endmodule